// File: doc/BRIEF.md
# Cache Line Word Compressor

This block takes one 64-byte cache line as sixteen 32-bit words, two words per accepted beat, and turns it into a bit-packed stream of variable-length codes. A word is coded as all-zero, as a single nonzero low byte, as a full match against a small dictionary, as an upper-half match, or as a raw literal. The dictionary holds recent literal and half-match words. It starts empty for every line and fills in arrival order.

A controller state machine has two states. In `ST_FILL` the block raises `in_ready` and takes one word pair on every cycle where `in_valid` is high. After the last pair of a line it takes the `fill_done` transition to `ST_EMIT`. In `ST_EMIT` it shows the packed result for exactly one cycle with `out_valid` high and `in_ready` low, clears its dictionary and accumulators, and takes the `emit_done` transition back to `ST_FILL`. The packed result never grows past the raw line size. If the codes would need more than 512 bits, the raw line is presented instead and the line is flagged as not compressed.

Top module: `lcmp_line_compressor`

## Requirements
- R1: While reset is asserted and after its release, `out_valid` is 0, `out_len` is 0 and `in_ready` is 1.
- R2: A line is eight accepted beats, with `in_word_a` earlier in the line than `in_word_b`. `out_valid` is high for exactly one cycle, the cycle after the eighth accepted beat. During that cycle `in_ready` is 0 and `in_valid` has no effect.
- R3: An all-zero word emits code `00`, 2 bits.
- R4: A word whose upper 24 bits are zero and whose low byte is nonzero emits `1101` followed by that byte, 12 bits.
- R5: A word equal to a valid dictionary entry emits `10` followed by the 4-bit entry index, 6 bits.
- R6: A word whose upper 16 bits equal those of a valid entry emits `1100`, the 4-bit index and the low 16 bits, 24 bits. When several entries qualify, the lowest index is used.
- R7: Any other word emits `01` followed by the 32-bit word, 34 bits.
- R8: The checks are made in a fixed order: zero, low byte, full match, half match, literal.
- R9: Only words coded by R6 or R7 are written into the dictionary, at a write pointer that starts at entry 0 for each line and advances by one per insertion. The dictionary is empty at the start of every line.
- R10: The second word of a beat is classified as if the first word of that beat had already been inserted.
- R11: Stream bit k sits at `out_bits[543-k]`. Each code is written most significant bit first, and codes follow word order. Unused low bits are 0. `out_len` is the sum of the code lengths.
- R12: If that sum exceeds 512, then `out_comp` is 0, `out_len` is 512, `out_bits[543:32]` holds the sixteen words with word 0 most significant, and the low 32 bits are 0. Otherwise `out_comp` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word pair offered |
| in_ready | output | 1 | Block can take a pair |
| in_word_a | input | 32 | Earlier word of the pair |
| in_word_b | input | 32 | Later word of the pair |
| out_valid | output | 1 | Packed result present (one cycle) |
| out_bits | output | 544 | Packed stream, left aligned |
| out_len | output | 10 | Stream length in bits |
| out_comp | output | 1 | 1 if the line was compressed, 0 if raw |

## Verification
The checker watches the handshake framing on every cycle. It confirms that the result pulse follows the eighth accepted beat and lasts one cycle, that input is refused during that pulse, that the length never exceeds 512, and that a raw fallback always reports 512 bits with a zero tail. The bench has to supply the content of the stream: code choice and priority, lowest-index selection, dictionary clearing between lines, and the same-beat lookahead of the second word. It does this by comparing every packed bit against a serial reference model and against hand-derived code fields.

// File: rtl/lcmp_pkg.sv
package lcmp_pkg;
    localparam int WORD_W  = 32;
    localparam int FIELD_W = WORD_W + 2;
    localparam int FLEN_W  = $clog2(FIELD_W + 1);

    typedef enum logic [2:0] {
        K_ZERO,
        K_BYTE,
        K_FULL,
        K_HALF,
        K_RAW
    } word_kind_t;

    typedef enum logic {
        ST_FILL,
        ST_EMIT
    } ctrl_state_t;
endpackage

// File: rtl/lcmp_word_code.sv
module lcmp_word_code
    import lcmp_pkg::*;
#(
    parameter int DICT_N = 16,
    parameter int IDX_W  = $clog2(DICT_N)
) (
    input  logic [WORD_W-1:0]             word,
    input  logic [DICT_N-1:0][WORD_W-1:0] ents,
    input  logic [DICT_N-1:0]             vld,
    output logic [FIELD_W-1:0]            field,
    output logic [FLEN_W-1:0]             flen,
    output logic                          push
);
    logic             full_hit, half_hit;
    logic [IDX_W-1:0] full_idx, half_idx;
    word_kind_t       kind;
    logic [FIELD_W-1:0] val;

    // parallel compare, descending scan leaves the lowest qualifying index
    always_comb begin
        full_hit = 1'b0;
        half_hit = 1'b0;
        full_idx = '0;
        half_idx = '0;
        for (int i = DICT_N - 1; i >= 0; i--) begin
            if (vld[i] && ents[i] == word) begin
                full_hit = 1'b1;
                full_idx = IDX_W'(i);
            end
            if (vld[i] && ents[i][WORD_W-1:WORD_W/2] == word[WORD_W-1:WORD_W/2]) begin
                half_hit = 1'b1;
                half_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        if (word == '0)                   kind = K_ZERO;
        else if (word[WORD_W-1:8] == '0)  kind = K_BYTE;
        else if (full_hit)                kind = K_FULL;
        else if (half_hit)                kind = K_HALF;
        else                              kind = K_RAW;
    end

    always_comb begin
        unique case (kind)
            K_ZERO: begin
                val  = '0;
                flen = FLEN_W'(2);
            end
            K_BYTE: begin
                val  = FIELD_W'({4'b1101, word[7:0]});
                flen = FLEN_W'(12);
            end
            K_FULL: begin
                val  = FIELD_W'({2'b10, full_idx});
                flen = FLEN_W'(2 + IDX_W);
            end
            K_HALF: begin
                val  = FIELD_W'({4'b1100, half_idx, word[WORD_W/2-1:0]});
                flen = FLEN_W'(4 + IDX_W + WORD_W / 2);
            end
            default: begin
                val  = {2'b01, word};
                flen = FLEN_W'(FIELD_W);
            end
        endcase
        field = val << (FLEN_W'(FIELD_W) - flen);
        push  = (kind == K_RAW) || (kind == K_HALF);
    end
endmodule

// File: rtl/lcmp_pair_pack.sv
module lcmp_pair_pack
    import lcmp_pkg::*;
(
    input  logic [FIELD_W-1:0]   field_a,
    input  logic [FLEN_W-1:0]    len_a,
    input  logic [FIELD_W-1:0]   field_b,
    input  logic [FLEN_W-1:0]    len_b,
    output logic [2*FIELD_W-1:0] pair_field,
    output logic [FLEN_W:0]      pair_len
);
    always_comb begin
        pair_field = {field_a, {FIELD_W{1'b0}}} | ({field_b, {FIELD_W{1'b0}}} >> len_a);
        pair_len   = {1'b0, len_a} + {1'b0, len_b};
    end
endmodule

// File: rtl/lcmp_dict.sv
module lcmp_dict
    import lcmp_pkg::*;
#(
    parameter int DICT_N = 16,
    parameter int IDX_W  = $clog2(DICT_N)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          wr_en,
    input  logic                          push_a,
    input  logic [WORD_W-1:0]             word_a,
    input  logic                          push_b,
    input  logic [WORD_W-1:0]             word_b,
    output logic [DICT_N-1:0][WORD_W-1:0] ents,
    output logic [DICT_N-1:0]             vld,
    output logic [DICT_N-1:0][WORD_W-1:0] ents_look,
    output logic [DICT_N-1:0]             vld_look
);
    logic [IDX_W-1:0] wp, wp_b;

    assign wp_b = wp + IDX_W'(push_a);

    // view seen by the later word: includes the earlier word's pending insert
    for (genvar g = 0; g < DICT_N; g++) begin : g_look
        logic hit;
        assign hit          = push_a && (wp == IDX_W'(g));
        assign ents_look[g] = hit ? word_a : ents[g];
        assign vld_look[g]  = vld[g] | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ents <= '0;
            vld  <= '0;
            wp   <= '0;
        end else if (clr) begin
            ents <= '0;
            vld  <= '0;
            wp   <= '0;
        end else if (wr_en) begin
            if (push_a) begin
                ents[wp] <= word_a;
                vld[wp]  <= 1'b1;
            end
            if (push_b) begin
                ents[wp_b] <= word_b;
                vld[wp_b]  <= 1'b1;
            end
            wp <= wp_b + IDX_W'(push_b);
        end
    end
endmodule

// File: rtl/lcmp_line_compressor.sv
module lcmp_line_compressor
    import lcmp_pkg::*;
#(
    parameter int LINE_WORDS = 16,
    parameter int DICT_N     = 16,
    localparam int BUF_W     = LINE_WORDS * FIELD_W,
    localparam int LEN_W     = $clog2(BUF_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word_a,
    input  logic [WORD_W-1:0] in_word_b,
    output logic              out_valid,
    output logic [BUF_W-1:0]  out_bits,
    output logic [LEN_W-1:0]  out_len,
    output logic              out_comp
);
    localparam int BEATS  = LINE_WORDS / 2;
    localparam int BEAT_W = $clog2(BEATS);
    localparam int RAW_W  = LINE_WORDS * WORD_W;
    localparam int IDX_W  = $clog2(DICT_N);

    ctrl_state_t state, state_nx;
    logic [BEAT_W-1:0] beat;
    logic [BUF_W-1:0]  acc_buf;
    logic [LEN_W-1:0]  acc_len;
    logic [RAW_W-1:0]  raw_acc;
    logic              accept, overflow;

    logic [DICT_N-1:0][WORD_W-1:0] ents, ents_look;
    logic [DICT_N-1:0]             vld, vld_look;
    logic [FIELD_W-1:0]            field_a, field_b;
    logic [FLEN_W-1:0]             len_a, len_b;
    logic                          push_a, push_b;
    logic [2*FIELD_W-1:0]          pair_field;
    logic [FLEN_W:0]               pair_len;

    assign accept = in_valid && (state == ST_FILL);

    lcmp_word_code #(.DICT_N(DICT_N), .IDX_W(IDX_W)) u_code_a (
        .word(in_word_a), .ents(ents), .vld(vld),
        .field(field_a), .flen(len_a), .push(push_a)
    );

    lcmp_word_code #(.DICT_N(DICT_N), .IDX_W(IDX_W)) u_code_b (
        .word(in_word_b), .ents(ents_look), .vld(vld_look),
        .field(field_b), .flen(len_b), .push(push_b)
    );

    lcmp_dict #(.DICT_N(DICT_N), .IDX_W(IDX_W)) u_dict (
        .clk(clk), .rst_n(rst_n), .clr(state == ST_EMIT), .wr_en(accept),
        .push_a(push_a), .word_a(in_word_a), .push_b(push_b), .word_b(in_word_b),
        .ents(ents), .vld(vld), .ents_look(ents_look), .vld_look(vld_look)
    );

    lcmp_pair_pack u_pack (
        .field_a(field_a), .len_a(len_a), .field_b(field_b), .len_b(len_b),
        .pair_field(pair_field), .pair_len(pair_len)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FILL;
        else        state <= state_nx;
    end

    // transitions: fill_done, emit_done
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FILL: if (accept && beat == BEAT_W'(BEATS - 1)) state_nx = ST_EMIT;
            ST_EMIT: state_nx = ST_FILL;
        endcase
    end

    // outputs
    assign overflow = acc_len > LEN_W'(RAW_W);
    always_comb begin
        unique case (state)
            ST_FILL: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
                out_comp  = 1'b0;
                out_len   = '0;
                out_bits  = '0;
            end
            ST_EMIT: begin
                in_ready  = 1'b0;
                out_valid = 1'b1;
                out_comp  = !overflow;
                out_len   = overflow ? LEN_W'(RAW_W) : acc_len;
                out_bits  = overflow ? {raw_acc, {(BUF_W - RAW_W){1'b0}}} : acc_buf;
            end
        endcase
    end

    // line accumulators
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat    <= '0;
            acc_buf <= '0;
            acc_len <= '0;
            raw_acc <= '0;
        end else if (state == ST_EMIT) begin
            beat    <= '0;
            acc_buf <= '0;
            acc_len <= '0;
            raw_acc <= '0;
        end else if (accept) begin
            beat    <= beat + 1'b1;
            acc_buf <= acc_buf | ({pair_field, {(BUF_W - 2*FIELD_W){1'b0}}} >> acc_len);
            acc_len <= acc_len + LEN_W'(pair_len);
            raw_acc <= raw_acc |
                       ({in_word_a, in_word_b, {(RAW_W - 2*WORD_W){1'b0}}} >> {beat, 6'b0});
        end
    end
endmodule

// File: rtl/lcmp_checker.sv
module lcmp_checker #(
    parameter int LINE_WORDS = 16,
    parameter int BUF_W      = 544,
    parameter int LEN_W      = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic [BUF_W-1:0] out_bits,
    input logic [LEN_W-1:0] out_len,
    input logic             out_comp
);
    localparam int BEATS  = LINE_WORDS / 2;
    localparam int BEAT_W = $clog2(BEATS);
    localparam int RAW_W  = LINE_WORDS * 32;

    logic [BEAT_W-1:0] seen;
    logic              acc;
    assign acc = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   seen <= '0;
        else if (acc) seen <= seen + 1'b1;
    end

    a_r2_pulse_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && seen == BEAT_W'(BEATS - 1)) |=> out_valid);
    a_r2_no_early_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && seen != BEAT_W'(BEATS - 1)) |=> !out_valid);
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    a_r2_refuse_in_emit: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
    a_r12_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_len <= LEN_W'(RAW_W));
    a_r12_raw_len: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_comp) |-> (out_len == LEN_W'(RAW_W) && out_bits[BUF_W-RAW_W-1:0] == '0));
    a_r3_min_len: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_comp) |-> out_len >= LEN_W'(2 * LINE_WORDS));
    a_r1_idle_len: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_len == '0);
endmodule

bind lcmp_line_compressor lcmp_checker #(
    .LINE_WORDS(LINE_WORDS), .BUF_W(BUF_W), .LEN_W(LEN_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_bits(out_bits), .out_len(out_len), .out_comp(out_comp)
);

// File: tb/lcmp_line_compressor_test.sv
module lcmp_line_compressor_test;
    localparam int CLK_PERIOD = 10;
    localparam int NROWS = 6;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] step;
        logic [9:0]  elen;
        logic        ecomp;
    } row_t;

    // word i of a row = base + i*step
    localparam row_t ROWS [NROWS] = '{
        '{32'h0000_0000, 32'h0000_0000, 10'd32,  1'b1},  // R3 all zero
        '{32'h0000_0005, 32'h0000_0000, 10'd192, 1'b1},  // R4 R8 byte beats full match
        '{32'h1234_5678, 32'h0000_0000, 10'd124, 1'b1},  // R5 R7 R10
        '{32'hABCD_0000, 32'h0000_0001, 10'd394, 1'b1},  // R6 lowest index
        '{32'h0001_0000, 32'h0001_0000, 10'd512, 1'b0},  // R12 fallback
        '{32'h0000_0100, 32'h0000_0100, 10'd394, 1'b1}   // R6 R8 zero upper half
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [31:0]  in_word_a = '0;
    logic [31:0]  in_word_b = '0;
    logic         out_valid;
    logic [543:0] out_bits;
    logic [9:0]   out_len;
    logic         out_comp;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit ended  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lcmp_line_compressor uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word_a(in_word_a), .in_word_b(in_word_b), .out_valid(out_valid),
        .out_bits(out_bits), .out_len(out_len), .out_comp(out_comp)
    );

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, act=%0d cycles exp<=20000", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [543:0] act, input logic [543:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // serial reference of the requirements
    function automatic void model(input logic [511:0] line, output logic [543:0] eb,
                                  output int el, output bit ec);
        logic [31:0] dict [16];
        bit          dv   [16];
        int          wp, pos;
        logic [33:0] val;
        int          len;
        bit          push;
        eb = '0; pos = 0; wp = 0;
        for (int j = 0; j < 16; j++) begin dict[j] = '0; dv[j] = 1'b0; end
        for (int i = 0; i < 16; i++) begin
            logic [31:0] w;
            int fi, hi;
            w = line[511 - 32*i -: 32];
            fi = -1; hi = -1;
            for (int j = 15; j >= 0; j--) begin
                if (dv[j] && dict[j] == w) fi = j;
                if (dv[j] && dict[j][31:16] == w[31:16]) hi = j;
            end
            push = 1'b0;
            if (w == 0) begin val = 34'b0; len = 2; end
            else if (w[31:8] == 0) begin val = {22'b0, 4'b1101, w[7:0]}; len = 12; end
            else if (fi >= 0) begin val = {28'b0, 2'b10, 4'(fi)}; len = 6; end
            else if (hi >= 0) begin val = {10'b0, 4'b1100, 4'(hi), w[15:0]}; len = 24; push = 1'b1; end
            else begin val = {2'b01, w}; len = 34; push = 1'b1; end
            for (int b = len - 1; b >= 0; b--) begin
                if (pos < 544) eb[543 - pos] = val[b];
                pos++;
            end
            if (push) begin dict[wp] = w; dv[wp] = 1'b1; wp = (wp + 1) % 16; end
        end
        if (pos > 512) begin eb = {line, 32'b0}; el = 512; ec = 1'b0; end
        else begin el = pos; ec = 1'b1; end
    endfunction

    // drives one line; on return the result pulse is visible
    task automatic send_line(input logic [511:0] line, input bit gaps, input bit junk_in_emit);
        for (int b = 0; b < 8; b++) begin
            @(negedge clk);
            if (gaps && b[0]) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid  = 1'b1;
            in_word_a = line[511 - 64*b -: 32];
            in_word_b = line[479 - 64*b -: 32];
        end
        @(negedge clk);
        in_valid  = junk_in_emit;
        in_word_a = 32'hFFFF_FFFF;
        in_word_b = 32'h0000_0042;
    endtask

    task automatic after_pulse();
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b0, "R2 pulse one cycle", 544'(out_valid), 544'(0));
    endtask

    task automatic check_model(input logic [511:0] line, input string tag);
        logic [543:0] eb; int el; bit ec;
        model(line, eb, el, ec);
        chk(out_valid == 1'b1, "R2 out_valid after 8th beat", 544'(out_valid), 544'(1));
        chk(in_ready == 1'b0, "R2 in_ready low in emit", 544'(in_ready), 544'(0));
        chk(out_bits == eb, {tag, " R11 packed bits"}, out_bits, eb);
        chk(out_len == 10'(el), {tag, " R11 length"}, 544'(out_len), 544'(el));
        chk(out_comp == ec, {tag, " R12 comp flag"}, 544'(out_comp), 544'(ec));
    endtask

    function automatic logic [511:0] make_line(input logic [31:0] base, input logic [31:0] step);
        logic [511:0] l;
        for (int i = 0; i < 16; i++) l[511 - 32*i -: 32] = base + 32'(i) * step;
        return l;
    endfunction

    initial begin
        logic [511:0] l;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(out_valid == 1'b0, "R1 out_valid in reset", 544'(out_valid), 544'(0));
        chk(in_ready == 1'b1, "R1 in_ready in reset", 544'(in_ready), 544'(1));
        chk(out_len == 10'd0, "R1 out_len in reset", 544'(out_len), 544'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 after release", 544'({out_valid, in_ready}), 544'(1));

        // table walk
        for (int r = 0; r < NROWS; r++) begin
            l = make_line(ROWS[r].base, ROWS[r].step);
            send_line(l, r[0], 1'b0);
            check_model(l, $sformatf("row%0d", r));
            chk(out_len == ROWS[r].elen, "R3 R4 R5 R6 R7 R12 row length", 544'(out_len), 544'(ROWS[r].elen));
            chk(out_comp == ROWS[r].ecomp, "R12 row flag", 544'(out_comp), 544'(ROWS[r].ecomp));
            after_pulse();
        end

        // R10: same word twice in one beat, second is a full match on entry 0
        l = '0;
        l[511 -: 64] = {32'hCAFE_BABE, 32'hCAFE_BABE};
        send_line(l, 1'b0, 1'b1);  // junk offered during emit must be ignored (R2)
        check_model(l, "r10_pair");
        chk(out_bits[543:504] == {2'b01, 32'hCAFE_BABE, 6'b100000}, "R10 lookahead full match",
            544'(out_bits[543:504]), 544'({2'b01, 32'hCAFE_BABE, 6'b100000}));
        chk(out_len == 10'd68, "R10 length", 544'(out_len), 544'(68));
        after_pulse();

        // R9: dictionary cleared, first word is a literal again; junk from emit not taken (R2)
        send_line(l, 1'b1, 1'b0);
        chk(out_bits[543:510] == {2'b01, 32'hCAFE_BABE}, "R9 cleared dictionary",
            544'(out_bits[543:510]), 544'({2'b01, 32'hCAFE_BABE}));
        chk(out_len == 10'd68, "R2 R9 length after emit junk", 544'(out_len), 544'(68));
        after_pulse();

        // R6 R9: two literals at entries 0,1; half match on entry 1
        l = '0;
        l[511 -: 96] = {32'h1111_0000, 32'h2222_0000, 32'h2222_5555};
        send_line(l, 1'b0, 1'b0);
        check_model(l, "r6_idx");
        chk(out_bits[475 -: 24] == {4'b1100, 4'h1, 16'h5555}, "R6 R9 half match index",
            544'(out_bits[475 -: 24]), 544'({4'b1100, 4'h1, 16'h5555}));
        chk(out_len == 10'd118, "R6 length", 544'(out_len), 544'(118));
        after_pulse();

        // R4 R8: low byte only, and a second-byte word that is a literal
        l = '0;
        l[511 -: 64] = {32'h0000_0080, 32'h0000_0180};
        send_line(l, 1'b0, 1'b0);
        check_model(l, "r4_byte");
        chk(out_bits[543:498] == {4'b1101, 8'h80, 2'b01, 32'h0000_0180}, "R4 R7 byte field",
            544'(out_bits[543:498]), 544'({4'b1101, 8'h80, 2'b01, 32'h0000_0180}));
        after_pulse();

        finish_run();
    end
endmodule